// File: doc/BRIEF.md
# Local Interrupt Priority Arbiter

This block arbitrates 256 interrupt vectors for one processor core. Each vector has a request bit and an in-service bit. The block derives a processor priority (PPR) from a programmable task priority (TPR) and the vector currently in service. It then offers the core the highest requested vector whose priority class lies above the PPR.

Sources raise a request with a one-cycle strobe and a vector number. The core takes the offered vector with a one-cycle accept strobe. An accepted vector moves from requested to in service and goes onto a nesting stack, whose priority classes rise strictly from bottom to top. An end-of-interrupt (EOI) strobe retires the highest vector in service and pops the stack. Vectors 0 to 31 are held like any other, but they are never offered and never retired.

The PPR and the offered vector are both registered outputs. An accept strobe is taken only when these outputs reflect the current state.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, `pendValid` is 0, `pprOut` is 0x00 and `stackOverflow` is 0. No vector is requested or in service, and the TPR is 0.
- R2: `pendVector` reports the highest requested vector in the range 32 to 255. Vector v is held in word v/32 at bit v%32, and its priority class is bits 7:4 of v.
- R3: A requested vector below 32 is never reported on `pendVector`.
- R4: `pendValid` is 1 only when the class of the highest requested vector is strictly greater than the class of the PPR. When the classes are equal or the request class is lower, `pendValid` is 0.
- R5: If the TPR class is greater than or equal to the class of the top in-service vector, the PPR equals the TPR. Otherwise the PPR equals the top in-service vector with bits 3:0 cleared. With nothing in service, the top is taken as 0.
- R6: A TPR write keeps bits 7:0 of the 32-bit `tprData` and discards the rest.
- R7: An accept clears the request bit of `pendVector`, sets its in-service bit and pushes it onto the stack. The pushed class is always above the class of the previous top.
- R8: An EOI clears the highest in-service bit among vectors 32 to 255 and pops the stack. With nothing in service, an EOI changes nothing.
- R9: If a request and an accept name the same vector in the same cycle, the request bit stays 1.
- R10: If an accept and an EOI arrive in the same cycle, the accept is served and the EOI is dropped.
- R11: When the stack already holds `STACK_DEPTH` entries, an accept is refused and the state is left unchanged. The refusal sets `stackOverflow`, which stays 1 until reset.
- R12: `pendValid`, `pendVector` and `pprOut` reflect a state change on the second rising edge after the stimulus. An accept strobe is ignored when `pendValid` is 0, or in the cycle right after a state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqSetValid | input | 1 | Set the request bit of `reqVector` |
| reqVector | input | 8 | Vector to request |
| ackStrobe | input | 1 | Core accepts the offered vector |
| eoiStrobe | input | 1 | End of interrupt |
| tprWrite | input | 1 | Write the task priority |
| tprData | input | 32 | TPR write data; only bits 7:0 are kept |
| pendValid | output | 1 | Offered vector is deliverable |
| pendVector | output | 8 | Offered vector |
| pprOut | output | 8 | Processor priority |
| stackOverflow | output | 1 | Sticky flag: an accept was refused on a full stack |

## Verification
A stimulus strobe updates the request, in-service, stack and TPR state on the first rising edge. The registered PPR and offered vector follow on the second rising edge, and the overflow flag is set by then as well. For every stimulus, the driver holds its strobe for exactly one cycle and waits for that second edge. Only then does it queue the expected outputs, and the monitor compares them at the following falling edge.

Two scenarios aim at the one-cycle staleness directly. In the first, an accept lands in the stale cycle and must be ignored. In the second, a request and an accept for the same vector arrive together. A second instance with a two-entry stack reaches the overflow case.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NUM_WORDS  = 8;
  localparam int WORD_W     = 32;
  localparam int NUM_VEC    = NUM_WORDS * WORD_W;
  localparam int VEC_W      = $clog2(NUM_VEC);
  localparam int WSEL_W     = $clog2(NUM_WORDS);
  localparam int BSEL_W     = $clog2(WORD_W);
  localparam int CLS_W      = 4;
  localparam int FIRST_LIVE = WORD_W;
  localparam int TPR_BUS_W  = 32;

  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [CLS_W-1:0] cls_t;
  typedef logic [NUM_WORDS-1:0][WORD_W-1:0] words_t;

  typedef struct packed {
    logic found;
    vec_t vec;
  } hit_t;

  // strobes from control to datapath
  typedef struct packed {
    logic doPush;
    logic doPop;
    logic doOverflow;
  } ctl_t;

  function automatic cls_t clsOf(vec_t v);
    return v[VEC_W-1 -: CLS_W];
  endfunction

  // highest set bit, scanning words from the top down to word 1
  function automatic hit_t scanTop(words_t w);
    hit_t h;
    h = '0;
    for (int i = NUM_WORDS - 1; i >= 1; i--) begin
      if (!h.found && (|w[i])) begin
        h.found = 1'b1;
        for (int b = 0; b < WORD_W; b++)
          if (w[i][b]) h.vec = vec_t'(i * WORD_W + b);
      end
    end
    return h;
  endfunction
endpackage

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic ackStrobe,
  input  logic eoiStrobe,
  input  logic reqSetValid,
  input  logic tprWrite,
  input  logic pendValid,
  input  logic eoiFound,
  input  logic stackFull,
  output ctl_t ctl
);
  logic staleQ;
  logic accOk;

  assign accOk          = ackStrobe && pendValid && !staleQ;
  assign ctl.doPush     = accOk && !stackFull;
  assign ctl.doOverflow = accOk && stackFull;
  assign ctl.doPop      = eoiStrobe && eoiFound && !accOk;

  always_ff @(posedge clk) begin
    if (!rstN) staleQ <= 1'b0;
    else       staleQ <= reqSetValid || ctl.doPush || ctl.doPop || tprWrite;
  end

  // R12: right after a request lands, the offered vector is stale
  p_stale_ack_r12: assert property (@(posedge clk) disable iff (!rstN)
    reqSetValid |=> !ctl.doPush);
endmodule

// File: rtl/irq_arb_data.sv
module irq_arb_data
  import irq_arb_pkg::*;
#(
  parameter int STACK_DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqSetValid,
  input  vec_t                 reqVector,
  input  logic                 tprWrite,
  input  logic [TPR_BUS_W-1:0] tprData,
  input  ctl_t                 ctl,
  output logic                 pendValid,
  output vec_t                 pendVector,
  output vec_t                 pprOut,
  output logic                 stackOverflow,
  output logic                 eoiFound,
  output logic                 stackFull
);
  localparam int SP_W = $clog2(STACK_DEPTH + 1);

  words_t irrWords, isrWords;
  vec_t   stk [0:STACK_DEPTH];
  logic [SP_W-1:0] sp;
  vec_t   tprQ, pprQ, pendVecQ;
  logic   pendValidQ, ovfQ;

  vec_t   topVec, pprNow;
  hit_t   irrHit, isrHit;
  logic   pendNow;

  assign topVec    = stk[sp];
  assign irrHit    = scanTop(irrWords);
  assign isrHit    = scanTop(isrWords);
  assign eoiFound  = isrHit.found;
  assign stackFull = (sp == SP_W'(STACK_DEPTH));

  always_comb begin
    if (clsOf(tprQ) >= clsOf(topVec)) pprNow = tprQ;
    else                              pprNow = {clsOf(topVec), {(VEC_W-CLS_W){1'b0}}};
  end

  assign pendNow = irrHit.found && (clsOf(irrHit.vec) > clsOf(pprNow));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irrWords   <= '0;
      isrWords   <= '0;
      for (int i = 0; i <= STACK_DEPTH; i++) stk[i] <= '0;
      sp         <= '0;
      tprQ       <= '0;
      pprQ       <= '0;
      pendVecQ   <= '0;
      pendValidQ <= 1'b0;
      ovfQ       <= 1'b0;
    end else begin
      if (ctl.doPush) begin
        irrWords[pendVecQ[VEC_W-1 -: WSEL_W]][pendVecQ[BSEL_W-1:0]] <= 1'b0;
        isrWords[pendVecQ[VEC_W-1 -: WSEL_W]][pendVecQ[BSEL_W-1:0]] <= 1'b1;
        stk[sp + SP_W'(1)] <= pendVecQ;
        sp <= sp + SP_W'(1);
      end
      if (ctl.doPop) begin
        isrWords[isrHit.vec[VEC_W-1 -: WSEL_W]][isrHit.vec[BSEL_W-1:0]] <= 1'b0;
        sp <= sp - SP_W'(1);
      end
      // a request issued later in program order wins over the accept clear
      if (reqSetValid)
        irrWords[reqVector[VEC_W-1 -: WSEL_W]][reqVector[BSEL_W-1:0]] <= 1'b1;
      if (tprWrite)       tprQ <= tprData[VEC_W-1:0];
      if (ctl.doOverflow) ovfQ <= 1'b1;
      pprQ       <= pprNow;
      pendVecQ   <= irrHit.vec;
      pendValidQ <= pendNow;
    end
  end

  assign pendValid     = pendValidQ;
  assign pendVector    = pendVecQ;
  assign pprOut        = pprQ;
  assign stackOverflow = ovfQ;

  // R7: nested classes rise strictly
  p_push_class_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doPush |-> clsOf(pendVecQ) > clsOf(topVec));
  // R8: the in-service scan and the stack agree on the top vector
  p_eoi_top_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sp != '0) |-> (isrHit.found && isrHit.vec == topVec));
  // R11: stack pointer never passes the depth
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rstN)
    sp <= SP_W'(STACK_DEPTH));
  // R11: overflow flag is sticky
  p_sticky_ovf_r11: assert property (@(posedge clk) disable iff (!rstN)
    ovfQ |=> ovfQ);
  // R3: reserved vectors are never offered
  p_reserved_r3: assert property (@(posedge clk) disable iff (!rstN)
    pendValidQ |-> pendVecQ >= vec_t'(FIRST_LIVE));
  // R4: an offered vector lies above the reported priority
  p_pend_above_r4: assert property (@(posedge clk) disable iff (!rstN)
    pendValidQ |-> clsOf(pendVecQ) > clsOf(pprQ));
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int STACK_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqSetValid,
  input  logic [7:0]  reqVector,
  input  logic        ackStrobe,
  input  logic        eoiStrobe,
  input  logic        tprWrite,
  input  logic [31:0] tprData,
  output logic        pendValid,
  output logic [7:0]  pendVector,
  output logic [7:0]  pprOut,
  output logic        stackOverflow
);
  ctl_t ctl;
  logic eoiFound, stackFull;

  irq_arb_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .ackStrobe(ackStrobe), .eoiStrobe(eoiStrobe),
    .reqSetValid(reqSetValid), .tprWrite(tprWrite),
    .pendValid(pendValid), .eoiFound(eoiFound), .stackFull(stackFull),
    .ctl(ctl)
  );

  irq_arb_data #(.STACK_DEPTH(STACK_DEPTH)) i_data (
    .clk(clk), .rstN(rstN),
    .reqSetValid(reqSetValid), .reqVector(reqVector),
    .tprWrite(tprWrite), .tprData(tprData),
    .ctl(ctl),
    .pendValid(pendValid), .pendVector(pendVector), .pprOut(pprOut),
    .stackOverflow(stackOverflow), .eoiFound(eoiFound), .stackFull(stackFull)
  );
endmodule

// File: tb/test_irq_prio_arbiter.sv
module test_irq_prio_arbiter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic sel = 1'b0;
  logic reqSet = 1'b0, ack = 1'b0, eoi = 1'b0, tprWr = 1'b0;
  logic [7:0] reqVec = '0;
  logic [31:0] tprDat = '0;

  logic pvA, ovfA, pvB, ovfB;
  logic [7:0] vecA, pprA, vecB, pprB;

  irq_prio_arbiter i_irq_prio_arbiter (
    .clk(clk), .rstN(rstN),
    .reqSetValid(reqSet & ~sel), .reqVector(reqVec),
    .ackStrobe(ack & ~sel), .eoiStrobe(eoi & ~sel),
    .tprWrite(tprWr & ~sel), .tprData(tprDat),
    .pendValid(pvA), .pendVector(vecA), .pprOut(pprA), .stackOverflow(ovfA)
  );

  irq_prio_arbiter #(.STACK_DEPTH(2)) i_irq_prio_arbiter_small (
    .clk(clk), .rstN(rstN),
    .reqSetValid(reqSet & sel), .reqVector(reqVec),
    .ackStrobe(ack & sel), .eoiStrobe(eoi & sel),
    .tprWrite(tprWr & sel), .tprData(tprDat),
    .pendValid(pvB), .pendVector(vecB), .pprOut(pprB), .stackOverflow(ovfB)
  );

  wire       pv  = sel ? pvB  : pvA;
  wire [7:0] vec = sel ? vecB : vecA;
  wire [7:0] ppr = sel ? pprB : pprA;
  wire       ovf = sel ? ovfB : ovfA;

  typedef struct {
    logic       pv;
    logic [7:0] vec;
    logic [7:0] ppr;
    logic       ovf;
    string      tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  task automatic expectNow(logic epv, logic [7:0] evec, logic [7:0] eppr, logic eovf, string tag);
    exp_t e;
    e.pv = epv; e.vec = evec; e.ppr = eppr; e.ovf = eovf; e.tag = tag;
    q.push_back(e);
  endtask

  // one-cycle strobe, then wait for the second rising edge
  task automatic op(logic s, logic a, logic e, logic t, logic [7:0] v, logic [31:0] d);
    @(negedge clk);
    reqSet = s; ack = a; eoi = e; tprWr = t; reqVec = v; tprDat = d;
    @(negedge clk);
    reqSet = 1'b0; ack = 1'b0; eoi = 1'b0; tprWr = 1'b0;
    @(posedge clk); #1;
  endtask

  // request, then accept in the very next cycle
  task automatic setThenAck(logic [7:0] v);
    @(negedge clk);
    reqSet = 1'b1; reqVec = v;
    @(negedge clk);
    reqSet = 1'b0; ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    @(posedge clk); #1;
  endtask

  // monitor
  initial begin
    exp_t e;
    logic ok;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        total++;
        ok = (pv == e.pv) && (!e.pv || vec == e.vec) && (ppr == e.ppr) && (ovf == e.ovf);
        if (!ok) begin
          bad++;
          $display("FAIL %s: got pv=%0d vec=%h ppr=%h ovf=%0d, expected pv=%0d vec=%h ppr=%h ovf=%0d",
                   e.tag, pv, vec, ppr, ovf, e.pv, e.vec, e.ppr, e.ovf);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    expectNow(0, 8'h00, 8'h00, 0, "R1 reset state");

    op(1,0,0,0, 8'h10, 0);          expectNow(0, 8'h00, 8'h00, 0, "R3 vector 0x10 not offered");
    op(1,0,0,0, 8'h45, 0);          expectNow(1, 8'h45, 8'h00, 0, "R2 single request 0x45");
    op(1,0,0,0, 8'h83, 0);          expectNow(1, 8'h83, 8'h00, 0, "R2 highest across words");
    op(0,0,0,1, 8'h00, 32'h1234_5683); expectNow(0, 8'h00, 8'h83, 0, "R6 low byte kept, R4 equal class blocked");
    op(0,0,0,1, 8'h00, 32'h0000_0040); expectNow(1, 8'h83, 8'h40, 0, "R5 ppr follows tpr");
    op(0,1,0,0, 8'h00, 0);          expectNow(0, 8'h00, 8'h80, 0, "R7 accept 0x83 raises ppr");
    op(0,1,0,0, 8'h00, 0);          expectNow(0, 8'h00, 8'h80, 0, "R12 accept without pending ignored");
    op(0,0,0,1, 8'h00, 32'h85);     expectNow(0, 8'h00, 8'h85, 0, "R5 tpr class equal to in-service wins");
    op(0,0,0,1, 8'h00, 32'h40);     expectNow(0, 8'h00, 8'h80, 0, "R5 in-service class wins");
    op(1,0,0,0, 8'h9A, 0);          expectNow(1, 8'h9A, 8'h80, 0, "R4 higher class offered");
    setThenAck(8'hC1);              expectNow(1, 8'hC1, 8'h80, 0, "R12 accept in stale cycle ignored");
    op(0,1,1,0, 8'h00, 0);          expectNow(0, 8'h00, 8'hC0, 0, "R10 accept wins over EOI");
    op(0,0,1,0, 8'h00, 0);          expectNow(1, 8'h9A, 8'h80, 0, "R8 EOI retires top");
    op(1,1,0,0, 8'h9A, 0);          expectNow(0, 8'h00, 8'h90, 0, "R9 accept with same-vector request");
    op(0,0,1,0, 8'h00, 0);          expectNow(1, 8'h9A, 8'h80, 0, "R9 request bit kept");
    op(0,0,1,0, 8'h00, 0);          expectNow(1, 8'h9A, 8'h40, 0, "R8 last EOI returns ppr to tpr");
    op(0,0,1,0, 8'h00, 0);          expectNow(1, 8'h9A, 8'h40, 0, "R8 EOI with nothing in service");
    op(0,0,0,1, 8'h00, 32'h0);      expectNow(1, 8'h9A, 8'h00, 0, "R6 tpr cleared");

    @(negedge clk); @(negedge clk);
    sel = 1'b1;
    @(posedge clk); #1;
    op(1,0,0,0, 8'h40, 0);          expectNow(1, 8'h40, 8'h00, 0, "R2 small instance request");
    op(0,1,0,0, 8'h00, 0);          expectNow(0, 8'h00, 8'h40, 0, "R7 first nest level");
    op(1,0,0,0, 8'h60, 0);          expectNow(1, 8'h60, 8'h40, 0, "R4 nested request offered");
    op(0,1,0,0, 8'h00, 0);          expectNow(0, 8'h00, 8'h60, 0, "R7 second nest level");
    op(1,0,0,0, 8'h80, 0);          expectNow(1, 8'h80, 8'h60, 0, "R4 third request offered");
    op(0,1,0,0, 8'h00, 0);          expectNow(1, 8'h80, 8'h60, 1, "R11 accept on full stack refused");
    op(0,0,1,0, 8'h00, 0);          expectNow(1, 8'h80, 8'h40, 1, "R11 overflow flag sticky");

    wait (q.size() == 0);
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule